// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This controller runs a three-wire serial EEPROM bus from a synchronous core. It owns the select line, the serial clock and the data line towards the memory, and it samples the data line coming back from the memory through a two-stage synchronizer. A host starts an operation with a one-cycle `req_start` pulse. The pulse carries a right-aligned bit string, a bit count, a flag that asks for a 16-bit word to be read back, and a flag that asks the controller to wait until the memory reports that its internal write or erase has finished.

Every operation follows a fixed order. The controller first prepares the bus and sends the outgoing bits. If the host asked for it, a 16-bit read follows, and then the commit-and-poll wait. The operation ends with a deselect plus one clock pulse. Every pin state is held for one delay period. The period is derived from the clock frequency and delay parameters (50 µs at 200 MHz by default), so a test build can use a much shorter period. When the operation ends, `done_o` pulses for one cycle and `busy_o` drops. In that same cycle the captured word and the wait result appear on the outputs.

Top module: `ee3w_master`

## Requirements
- R1: While reset is asserted and after it is released, select, serial clock and data-to-memory are all 0, `busy_o` and `done_o` are 0, and `rd_word_o` and `wait_timeout_o` read 0.
- R2: An accepted start first drives select, clock and data low for one period, then raises select with clock and data still low for one period.
- R3: The low `req_len` bits of `req_bits` are sent most significant first. For each bit, data takes the bit value with clock low for one period, then clock is high for one period with data unchanged.
- R4: After the last outgoing bit, data returns to 0 with clock low and select high for one period. Data then stays 0 until the operation ends.
- R5: With `req_read` set, the controller issues 16 clock pulses, each high for one period and then low for one period. At the end of each high period it samples the memory line, delayed by the two-stage synchronizer, and assembles the word most significant bit first. `rd_word_o` takes the word in the `done_o` cycle. Operations without a read leave `rd_word_o` unchanged.
- R6: With `req_wait` set, a commit sequence runs before any polling. It has four states of one period each, in this order (select, clock): (0,0), (0,1), (1,1), (1,0).
- R7: After the commit, each poll holds select high and clock low for one period and then samples the synchronized memory line. The first 1 ends polling with `wait_timeout_o` = 0. If POLL_LIMIT polls all read 0, `wait_timeout_o` = 1. An operation without a wait reports 0.
- R8: Every operation ends with select low, clock high for one period, then clock low for one period. In the next cycle `done_o` is 1 for exactly one cycle and `busy_o` is 0.
- R9: `busy_o` rises in the cycle after an accepted start. A start while busy is ignored. A start in the `done_o` cycle is accepted.
- R10: A `req_len` of 0 sends no bits: the R4 state follows the R2 states directly. A `req_len` above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse, sampled while idle |
| req_bits | input | 16 | Outgoing bit string, right-aligned |
| req_len | input | 5 | Number of outgoing bits (0 to 16, larger clamps to 16) |
| req_read | input | 1 | Read a 16-bit word after the outgoing bits |
| req_wait | input | 1 | Run commit and ready polling before cleanup |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_word_o | output | 16 | Last word read from the memory |
| wait_timeout_o | output | 1 | Last wait ended without a ready indication |
| mem_sel_o | output | 1 | Memory select |
| mem_clk_o | output | 1 | Memory serial clock |
| mem_dout_o | output | 1 | Serial data towards the memory |
| mem_din_i | input | 1 | Serial data from the memory |

## Verification
Commands are issued with lengths of 3, 8, 9, 11 and 16 bits and with alternating bit patterns, which separates MSB-first from LSB-first ordering and shows any missing or extra bits. A length of 0 and a length of 20 cover the clamp paths. The memory model rotates a non-symmetric word out on each clock rise, so a wrong sampling edge or a wrong synchronizer delay changes the captured word. Ready polling runs against a memory that is ready at once, one that becomes ready after a few polls, and one that never does, which distinguishes first-sample success, mid-poll success and timeout. Back-to-back starts and a start pulse in the middle of an operation check that starts are accepted only while idle.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

  typedef longint unsigned u64_t;

  // Bus phases; every non-idle phase lasts exactly one delay period.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PREP_LOW,
    PH_PREP_SEL,
    PH_OUT_SET,
    PH_OUT_HIGH,
    PH_OUT_TAIL,
    PH_IN_HIGH,
    PH_IN_LOW,
    PH_CMT_DESEL,
    PH_CMT_CLK,
    PH_CMT_SEL,
    PH_CMT_DROP,
    PH_POLL,
    PH_FIN_HIGH,
    PH_FIN_LOW
  } phase_e;

endpackage

// File: rtl/ee3w_period_timer.sv
module ee3w_period_timer #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic period_end
);

  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign period_end = run && (cnt_q == LAST);

  always_comb begin
    if (!run || period_end) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ee3w_sync.sv
module ee3w_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= {ff_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/ee3w_sequencer.sv
module ee3w_sequencer
  import ee3w_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned POLL_LIMIT = 200,
  localparam int unsigned LEN_W = $clog2(WORD_W + 1),
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] bits,
  input  logic [LEN_W-1:0]  len,
  input  logic              want_read,
  input  logic              want_wait,
  input  logic              period_end,
  input  logic              mem_bit,
  output logic              run,
  output logic              sel,
  output logic              sclk,
  output logic              dout,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              timed_out
);

  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0]    POLL_LAST = PW'(POLL_LIMIT - 1);
  localparam logic [IDX_W-1:0] IN_LAST   = IDX_W'(WORD_W - 1);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(WORD_W);

  phase_e             ph_q, ph_d;
  logic [WORD_W-1:0]  bits_q, bits_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               zero_q, zero_d;
  logic               rd_q, rd_d;
  logic               wt_q, wt_d;
  logic [IDX_W-1:0]   icnt_q, icnt_d;
  logic [PW-1:0]      poll_q, poll_d;
  logic [WORD_W-1:0]  shift_q, shift_d;
  logic               fail_q, fail_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic               to_q, to_d;
  logic               done_q, done_d;
  logic [LEN_W-1:0]   len_eff;

  assign len_eff = (len > LEN_MAX) ? LEN_MAX : len;

  // Phase after the outgoing bits or after the read
  function automatic phase_e after_read(input logic w);
    return w ? PH_CMT_DESEL : PH_FIN_HIGH;
  endfunction

  always_comb begin
    ph_d    = ph_q;
    bits_d  = bits_q;
    idx_d   = idx_q;
    zero_d  = zero_q;
    rd_d    = rd_q;
    wt_d    = wt_q;
    icnt_d  = icnt_q;
    poll_d  = poll_q;
    shift_d = shift_q;
    fail_d  = fail_q;
    word_d  = word_q;
    to_d    = to_q;
    done_d  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_PREP_LOW;
          bits_d = bits;
          zero_d = (len_eff == '0);
          idx_d  = IDX_W'(len_eff - 1'b1);
          rd_d   = want_read;
          wt_d   = want_wait;
          fail_d = 1'b0;
        end
      end
      PH_PREP_LOW:  if (period_end) ph_d = PH_PREP_SEL;
      PH_PREP_SEL:  if (period_end) ph_d = zero_q ? PH_OUT_TAIL : PH_OUT_SET;
      PH_OUT_SET:   if (period_end) ph_d = PH_OUT_HIGH;
      PH_OUT_HIGH: begin
        if (period_end) begin
          if (idx_q == '0) ph_d = PH_OUT_TAIL;
          else begin
            ph_d  = PH_OUT_SET;
            idx_d = idx_q - 1'b1;
          end
        end
      end
      PH_OUT_TAIL: begin
        if (period_end) begin
          if (rd_q) begin
            ph_d   = PH_IN_HIGH;
            icnt_d = '0;
          end else begin
            ph_d = after_read(wt_q);
          end
        end
      end
      PH_IN_HIGH: begin
        if (period_end) begin
          ph_d    = PH_IN_LOW;
          shift_d = {shift_q[WORD_W-2:0], mem_bit};
        end
      end
      PH_IN_LOW: begin
        if (period_end) begin
          if (icnt_q == IN_LAST) ph_d = after_read(wt_q);
          else begin
            ph_d   = PH_IN_HIGH;
            icnt_d = icnt_q + 1'b1;
          end
        end
      end
      PH_CMT_DESEL: if (period_end) ph_d = PH_CMT_CLK;
      PH_CMT_CLK:   if (period_end) ph_d = PH_CMT_SEL;
      PH_CMT_SEL:   if (period_end) ph_d = PH_CMT_DROP;
      PH_CMT_DROP: begin
        if (period_end) begin
          ph_d   = PH_POLL;
          poll_d = '0;
        end
      end
      PH_POLL: begin
        if (period_end) begin
          if (mem_bit) ph_d = PH_FIN_HIGH;
          else if (poll_q == POLL_LAST) begin
            ph_d   = PH_FIN_HIGH;
            fail_d = 1'b1;
          end else begin
            poll_d = poll_q + 1'b1;
          end
        end
      end
      PH_FIN_HIGH:  if (period_end) ph_d = PH_FIN_LOW;
      PH_FIN_LOW: begin
        if (period_end) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
          to_d   = fail_q;
          if (rd_q) word_d = shift_q;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      bits_q  <= '0;
      idx_q   <= '0;
      zero_q  <= 1'b0;
      rd_q    <= 1'b0;
      wt_q    <= 1'b0;
      icnt_q  <= '0;
      poll_q  <= '0;
      shift_q <= '0;
      fail_q  <= 1'b0;
      word_q  <= '0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      bits_q  <= bits_d;
      idx_q   <= idx_d;
      zero_q  <= zero_d;
      rd_q    <= rd_d;
      wt_q    <= wt_d;
      icnt_q  <= icnt_d;
      poll_q  <= poll_d;
      shift_q <= shift_d;
      fail_q  <= fail_d;
      word_q  <= word_d;
      to_q    <= to_d;
      done_q  <= done_d;
    end
  end

  // Pin decode from the registered phase
  always_comb begin
    sel  = 1'b0;
    sclk = 1'b0;
    case (ph_q)
      PH_PREP_SEL, PH_OUT_SET, PH_OUT_TAIL, PH_IN_LOW,
      PH_CMT_DROP, PH_POLL:                  sel = 1'b1;
      PH_OUT_HIGH, PH_IN_HIGH, PH_CMT_SEL: begin
        sel  = 1'b1;
        sclk = 1'b1;
      end
      PH_CMT_CLK, PH_FIN_HIGH:               sclk = 1'b1;
      default: ;
    endcase
  end

  assign dout      = ((ph_q == PH_OUT_SET) || (ph_q == PH_OUT_HIGH)) && bits_q[idx_q];
  assign run       = (ph_q != PH_IDLE);
  assign busy      = run;
  assign done      = done_q;
  assign word      = word_q;
  assign timed_out = to_q;

endmodule

// File: rtl/ee3w_master.sv
module ee3w_master
  import ee3w_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 200000,
  parameter int unsigned DELAY_NS    = 50000,
  parameter int unsigned POLL_LIMIT  = 200,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WORD_W      = 16,
  localparam int unsigned LEN_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [WORD_W-1:0] req_bits,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_read,
  input  logic              req_wait,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              wait_timeout_o,
  output logic              mem_sel_o,
  output logic              mem_clk_o,
  output logic              mem_dout_o,
  input  logic              mem_din_i
);

  // One period must outlast the synchronizer so a bit launched at a clock
  // rise is settled at the sampling point at the end of the high phase.
  localparam u64_t        RAW_TICKS = (u64_t'(CLK_KHZ) * u64_t'(DELAY_NS)) / u64_t'(1000000);
  localparam int unsigned MIN_TICKS = SYNC_STAGES + 1;
  localparam int unsigned TICKS     = (RAW_TICKS < u64_t'(MIN_TICKS)) ? MIN_TICKS : 32'(RAW_TICKS);

  logic run;
  logic period_end;
  logic din_sync;

  ee3w_period_timer #(.TICKS(TICKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .period_end (period_end)
  );

  ee3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mem_din_i),
    .q     (din_sync)
  );

  ee3w_sequencer #(.WORD_W(WORD_W), .POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_start),
    .bits       (req_bits),
    .len        (req_len),
    .want_read  (req_read),
    .want_wait  (req_wait),
    .period_end (period_end),
    .mem_bit    (din_sync),
    .run        (run),
    .sel        (mem_sel_o),
    .sclk       (mem_clk_o),
    .dout       (mem_dout_o),
    .busy       (busy_o),
    .done       (done_o),
    .word       (rd_word_o),
    .timed_out  (wait_timeout_o)
  );

endmodule

// File: rtl/ee3w_master_chk.sv
module ee3w_master_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] rd_word_o,
  input logic              wait_timeout_o,
  input logic              mem_sel_o,
  input logic              mem_clk_o,
  input logic              mem_dout_o
);

  // R1 / R8: an idle controller leaves the bus quiet
  p_idle_bus_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_sel_o && !mem_clk_o && !mem_dout_o));

  // R2: select never rises while data to the memory is high
  p_sel_rise_data_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sel_o) |-> !mem_dout_o);

  // R3: data changes only while the serial clock is low
  p_data_moves_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_dout_o) |-> !mem_clk_o);

  // R3: data holds across a high clock phase
  p_data_held_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_clk_o && $past(mem_clk_o)) |-> $stable(mem_dout_o));

  // R5: the read word changes only on completion
  p_word_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_word_o) |-> done_o);

  // R7: the wait result changes only on completion
  p_timeout_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wait_timeout_o) |-> done_o);

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8 / R9: busy ends exactly when done is raised
  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

endmodule

bind ee3w_master ee3w_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .rd_word_o      (rd_word_o),
  .wait_timeout_o (wait_timeout_o),
  .mem_sel_o      (mem_sel_o),
  .mem_clk_o      (mem_clk_o),
  .mem_dout_o     (mem_dout_o)
);

// File: tb/ee3w_master_bench.sv
`timescale 1ns/1ps
module ee3w_master_bench;

  localparam int P     = 4;   // 200 MHz x 20 ns delay
  localparam int LIMIT = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start;
  logic [15:0] req_bits;
  logic [4:0]  req_len;
  logic        req_read;
  logic        req_wait;
  logic        busy_o, done_o, wait_timeout_o;
  logic [15:0] rd_word_o;
  logic        mem_sel_o, mem_clk_o, mem_dout_o;
  logic        mem_din_i;

  always #2.5 clk = ~clk;

  ee3w_master #(.CLK_KHZ(200000), .DELAY_NS(20), .POLL_LIMIT(LIMIT)) u_ee3w_master (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_bits(req_bits),
    .req_len(req_len), .req_read(req_read), .req_wait(req_wait),
    .busy_o(busy_o), .done_o(done_o), .rd_word_o(rd_word_o),
    .wait_timeout_o(wait_timeout_o), .mem_sel_o(mem_sel_o),
    .mem_clk_o(mem_clk_o), .mem_dout_o(mem_dout_o), .mem_din_i(mem_din_i)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // ---------------- reference model state ----------------
  logic        e_sel = 0, e_clk = 0, e_dout = 0, e_busy = 0, e_done = 0, e_to = 0;
  logic [15:0] e_word = '0;
  string       tag = "R1";
  logic        h0 = 0, h1 = 0, h2 = 0;  // memory line seen at the last three edges
  logic        fin = 0;

  task automatic edge_step();
    @(posedge clk);
    h2 = h1; h1 = h0; h0 = mem_din_i;
  endtask

  task automatic hold(input logic s, input logic c, input logic d, input string t);
    for (int i = 0; i < P; i++) begin
      e_sel = s; e_clk = c; e_dout = d; e_busy = 1'b1; e_done = 1'b0; tag = t;
      edge_step();
    end
  endtask

  task automatic run_op();
    logic [15:0] b, w;
    int n;
    logic rd, wt, ok;
    string tx;
    b = req_bits; rd = req_read; wt = req_wait;
    n  = (req_len > 16) ? 16 : int'(req_len);
    tx = (req_len == 0 || req_len > 16) ? "R10" : "R3";
    w = '0; ok = 1'b0;
    hold(0, 0, 0, "R2");
    hold(1, 0, 0, "R2");
    for (int i = n - 1; i >= 0; i--) begin
      hold(1, 0, b[i], tx);
      hold(1, 1, b[i], tx);
    end
    hold(1, 0, 0, (n == 0) ? "R10" : "R4");
    if (rd) begin
      for (int i = 0; i < 16; i++) begin
        hold(1, 1, 0, "R5");
        w = {w[14:0], h2};
        hold(1, 0, 0, "R5");
      end
    end
    if (wt) begin
      hold(0, 0, 0, "R6");
      hold(0, 1, 0, "R6");
      hold(1, 1, 0, "R6");
      hold(1, 0, 0, "R6");
      for (int k = 0; k < LIMIT; k++) begin
        hold(1, 0, 0, "R7");
        if (h2) begin ok = 1'b1; break; end
      end
    end
    hold(0, 1, 0, "R8");
    hold(0, 0, 0, "R8");
    if (rd) e_word = w;
    e_to = wt && !ok;
    fin  = 1'b1;
  endtask

  initial begin
    wait (rst_n === 1'b1);
    forever begin
      e_sel = 0; e_clk = 0; e_dout = 0; e_busy = 0;
      e_done = fin; tag = fin ? "R8" : "R9";
      fin = 1'b0;
      edge_step();
      if (req_start) run_op();
    end
  end

  // ---------------- comparison on every clock ----------------
  task automatic cmp(input string t, input string nm, input logic [15:0] a, input logic [15:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, nm, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cmp("R1", "sel",  16'(mem_sel_o),  16'h0);
      cmp("R1", "clk",  16'(mem_clk_o),  16'h0);
      cmp("R1", "dout", 16'(mem_dout_o), 16'h0);
      cmp("R1", "busy", 16'(busy_o),     16'h0);
      cmp("R1", "done", 16'(done_o),     16'h0);
      cmp("R1", "word", rd_word_o,       16'h0);
      cmp("R1", "tmo",  16'(wait_timeout_o), 16'h0);
    end else begin
      cmp(tag,  "sel",  16'(mem_sel_o),  16'(e_sel));
      cmp(tag,  "clk",  16'(mem_clk_o),  16'(e_clk));
      cmp(tag,  "dout", 16'(mem_dout_o), 16'(e_dout));
      cmp("R9", "busy", 16'(busy_o),     16'(e_busy));
      cmp("R8", "done", 16'(done_o),     16'(e_done));
      cmp("R5", "word", rd_word_o,       e_word);
      cmp("R7", "tmo",  16'(wait_timeout_o), 16'(e_to));
    end
  end

  // ---------------- memory model ----------------
  logic [15:0] dev_word = 16'hC3A5;
  logic        dev_ready_mode = 0;
  int          ready_after = 0;
  logic        dev_prev_clk = 0, dev_prev_sel = 0, dev_rot = 0;
  int          since_sel = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_din_i = 1'b0;
      dev_prev_clk = 0; dev_prev_sel = 0; since_sel = 0;
    end else begin
      if (mem_sel_o && !dev_prev_sel) since_sel = 0;
      else since_sel++;
      if (mem_clk_o && !dev_prev_clk) begin
        dev_rot  = dev_word[15];
        dev_word = {dev_word[14:0], dev_word[15]};
      end
      mem_din_i    = dev_ready_mode ? (since_sel >= ready_after) : dev_rot;
      dev_prev_clk = mem_clk_o;
      dev_prev_sel = mem_sel_o;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_cmd(input logic [15:0] b, input logic [4:0] l, input logic r, input logic w);
    req_bits = b; req_len = l; req_read = r; req_wait = w; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_start = 0; req_bits = '0; req_len = '0; req_read = 0; req_wait = 0;
    mem_din_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_cmd(16'h05A3, 5'd11, 0, 0);                 // R3 R4 plain send
    // R5 read, with a start pulse during busy (R9)
    req_bits = 16'h0183; req_len = 5'd9; req_read = 1; req_wait = 0; req_start = 1;
    @(negedge clk);
    req_start = 0;
    repeat (12) @(negedge clk);
    req_bits = 16'hFFFF; req_len = 5'd16; req_read = 0; req_wait = 1; req_start = 1;
    @(negedge clk);
    req_start = 0;
    while (!done_o) @(negedge clk);

    dev_ready_mode = 1; ready_after = 13;
    run_cmd(16'h00A7, 5'd8, 0, 1);                  // R6 R7 ready mid-poll
    ready_after = 100000;
    run_cmd(16'h0015, 5'd5, 0, 1);                  // R7 timeout
    ready_after = 0;
    run_cmd(16'h0003, 5'd3, 1, 1);                  // R7 ready at first poll
    dev_ready_mode = 0;
    run_cmd(16'h8001, 5'd16, 1, 0);                 // R3 R5 full length
    run_cmd(16'h1234, 5'd0, 1, 0);                  // R10 zero length
    run_cmd(16'hBEEF, 5'd20, 0, 0);                 // R10 clamp
    run_cmd(16'h000A, 5'd4, 0, 0);                  // R5 word holds
    repeat (6) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule